// File: doc/BRIEF.md
# Reed-Solomon Parity and Syndrome Unit

This unit protects one sector of a NAND page with a Reed-Solomon code over GF(2^10) that carries eight 10-bit check symbols. Software starts a sector by setting a run bit. Each data byte then arrives on a byte strobe and is widened to a 10-bit symbol with its two upper bits zero. On a program pass the unit divides the byte stream by the generator polynomial, and the eight remainder symbols are the parity that software stores in the spare area. The field polynomial is x^10+x^3+1, and the generator has the roots alpha^1 through alpha^8.

On a read pass the same byte stream goes through the same division. Software then freezes the unit by reading a result register, and writes the eight stored parity symbols back through a load port. It writes one symbol per write, starting with symbol 8 and ending with symbol 1. After the eighth load, the unit evaluates the received remainder at alpha^1..alpha^8, one coefficient per cycle, while a busy flag is high. When busy falls, the four result registers hold the syndromes instead of the parity. An all-zero syndrome means the sector has no bit errors. Locating and correcting errors is left to software or to a separate unit.

Top module: `rs_check_unit`

## Requirements
- R1: After reset, run, busy, syndrome mode and clean are all 0, and all four result registers read 0.
- R2: A control write with the start bit set to 1 clears all eight stages, the byte count, the load count, the syndromes and syndrome mode, and sets run in the next cycle.
- R3: While run is set, every accepted byte is folded into the division. The first byte is the highest-degree coefficient. Parity symbol k is the coefficient of x^(k-1) in the remainder of D(x)*x^8 divided by g(x) = (x+alpha)(x+alpha^2)...(x+alpha^8), where alpha is the root x = 2.
- R4: A byte strobe has no effect while run is clear. It also has no effect in a cycle that carries a control write or a result read.
- R5: A result read strobe clears run at the next edge, and this freezes the stages.
- R6: At most MAX_BYTES (default 518) bytes are folded per sector. Any further bytes are ignored until the next start.
- R7: Result register j (select 0..3) holds symbol 2j+1 in bits [9:0] and symbol 2j+2 in bits [25:16]. All other bits are 0. In encode mode the symbols are parity; after the first load they are syndromes.
- R8: The load port is accepted only while run is clear, busy is low and fewer than eight loads have been taken. The n-th accepted load (n = 1..8) is XORed into stage 9-n, so symbols go in from 8 down to 1. The first accepted load sets syndrome mode. Any other load has no effect.
- R9: The edge that takes the eighth load raises busy. Busy then stays high for exactly eight cycles.
- R10: When busy falls, syndrome k equals the received codeword (data plus loaded parity) evaluated at alpha^k.
- R11: Clean is high exactly when syndrome mode is set, all eight loads are in, busy is low and all eight syndromes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start bit value written with ctl_wr |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| load_wr | input | 1 | Parity load write strobe |
| load_sym | input | 10 | Parity symbol being loaded |
| res_rd | input | 1 | Result register read strobe |
| res_sel | input | 2 | Result register select |
| res_data | output | 32 | Selected result register |
| run_o | output | 1 | Run bit |
| busy_o | output | 1 | Syndrome evaluation in progress |
| syn_mode_o | output | 1 | Result registers show syndromes |
| clean_o | output | 1 | Syndrome complete and all zero |

## Verification
The assertions assume that software drives at most one of the strobes ctl_wr, res_rd and load_wr in any cycle, although the design still defines what happens when they overlap. They also assume that nothing is loaded while a sector is still running. The bench drives each strobe for exactly one cycle at a time, from tasks that never overlap. It waits for busy to fall before it loads or reads again. The one exception is a load attempt made deliberately while run is set, to show that the unit ignores it.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int SYM_W = 10;
  localparam int NCHK  = 8;
  localparam logic [SYM_W-1:0] FIELD_RED = 10'h009;  // x^10 = x^3 + 1

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NCHK-1:0][SYM_W-1:0] symvec_t;
  typedef logic [NCHK:0][SYM_W-1:0] genvec_t;

  // Shift-and-add multiply in GF(2^10)
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t p;
    sym_t x;
    p = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_RED) : (x << 1);
    end
    return p;
  endfunction

  function automatic sym_t gf_apow(int e);
    sym_t p;
    p = sym_t'(1);
    for (int i = 0; i < e; i++) p = gf_mul(p, sym_t'(2));
    return p;
  endfunction

  // g(x) = prod (x + alpha^r), r = 1..NCHK ; entry j is coefficient of x^j
  function automatic genvec_t gen_coeffs();
    genvec_t g;
    g = '0;
    g[0] = sym_t'(1);
    for (int r = 1; r <= NCHK; r++) begin
      for (int j = NCHK; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], gf_apow(r));
      g[0] = gf_mul(g[0], gf_apow(r));
    end
    return g;
  endfunction

  // entry k holds alpha^(k+1)
  function automatic symvec_t root_pows();
    symvec_t v;
    for (int k = 0; k < NCHK; k++) v[k] = gf_apow(k + 1);
    return v;
  endfunction
endpackage

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int MAX_BYTES = 518
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_start,
  input  logic byte_vld,
  input  logic load_wr,
  input  logic res_rd,
  input  logic busy,
  output logic run,
  output logic clr,
  output logic fold,
  output logic load_en,
  output logic [$clog2(NCHK)-1:0] load_idx,
  output logic eval_go,
  output logic syn_mode,
  output logic loads_done
);
  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam int LCW = $clog2(NCHK + 1);
  localparam int LIW = $clog2(NCHK);

  logic [BCW-1:0] bcnt;
  logic [LCW-1:0] lcnt;

  assign clr        = ctl_wr & ctl_start;
  assign fold       = run & byte_vld & ~ctl_wr & ~res_rd & (bcnt < BCW'(MAX_BYTES));
  assign load_en    = load_wr & ~run & ~busy & ~ctl_wr & (lcnt < LCW'(NCHK));
  assign eval_go    = load_en & (lcnt == LCW'(NCHK - 1));
  assign loads_done = (lcnt == LCW'(NCHK));
  assign load_idx   = LIW'(NCHK - 1) - lcnt[LIW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      bcnt     <= '0;
      lcnt     <= '0;
      syn_mode <= 1'b0;
    end else begin
      if (ctl_wr)      run <= ctl_start;
      else if (res_rd) run <= 1'b0;
      if (clr) begin
        bcnt     <= '0;
        lcnt     <= '0;
        syn_mode <= 1'b0;
      end else begin
        if (fold) bcnt <= bcnt + 1'b1;
        if (load_en) begin
          lcnt     <= lcnt + 1'b1;
          syn_mode <= 1'b1;
        end
      end
    end
  end

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd && !ctl_wr |=> !run);
  a_r2_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> run && !syn_mode && !loads_done);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BCW'(MAX_BYTES));
  a_r8_go_completes_loads: assert property (@(posedge clk) disable iff (!rst_n)
    eval_go |=> loads_done && syn_mode);
endmodule

// File: rtl/rsc_lfsr.sv
module rsc_lfsr
  import rsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fold,
  input  logic [7:0] byte_in,
  input  logic load,
  input  logic [$clog2(NCHK)-1:0] load_idx,
  input  sym_t load_sym,
  output symvec_t stages
);
  localparam genvec_t GEN = gen_coeffs();

  sym_t fb;
  assign fb = {{(SYM_W-8){1'b0}}, byte_in} ^ stages[NCHK-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      stages <= '0;
    end else if (fold) begin
      stages[0] <= gf_mul(fb, GEN[0]);
      for (int k = 1; k < NCHK; k++) stages[k] <= stages[k-1] ^ gf_mul(fb, GEN[k]);
    end else if (load) begin
      stages[load_idx] <= stages[load_idx] ^ load_sym;
    end
  end

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> stages == '0);
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !fold && !load |=> $stable(stages));
endmodule

// File: rtl/rsc_syneval.sv
module rsc_syneval
  import rsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic go,
  input  symvec_t rem,
  output logic busy,
  output symvec_t syn
);
  localparam symvec_t ROOTS = root_pows();
  localparam int LIW = $clog2(NCHK);

  logic [LIW-1:0] hidx;

  // Horner evaluation of rem(x), highest coefficient first, all roots in parallel
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy <= 1'b0;
      hidx <= '0;
      syn  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      hidx <= LIW'(NCHK - 1);
      syn  <= '0;
    end else if (busy) begin
      for (int k = 0; k < NCHK; k++) syn[k] <= gf_mul(syn[k], ROOTS[k]) ^ rem[hidx];
      hidx <= hidx - 1'b1;
      if (hidx == '0) busy <= 1'b0;
    end
  end

  // checker-only run length of the busy pulse
  logic [LIW+1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= busy ? run_len + 1'b1 : '0;
  end

  a_r9_go_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go && !clr |=> busy);
  a_r9_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(clr) |-> run_len == (LIW+2)'(NCHK));
endmodule

// File: rtl/rs_check_unit.sv
module rs_check_unit
  import rsc_pkg::*;
#(
  parameter int MAX_BYTES = 518
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_start,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  input  logic        load_wr,
  input  logic [9:0]  load_sym,
  input  logic        res_rd,
  input  logic [1:0]  res_sel,
  output logic [31:0] res_data,
  output logic        run_o,
  output logic        busy_o,
  output logic        syn_mode_o,
  output logic        clean_o
);
  localparam int LIW = $clog2(NCHK);

  logic clr, fold, load_en, eval_go, syn_mode, loads_done, busy, run;
  logic [LIW-1:0] load_idx;
  symvec_t stages, syn, shown;

  rsc_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
    .byte_vld(byte_vld), .load_wr(load_wr), .res_rd(res_rd), .busy(busy),
    .run(run), .clr(clr), .fold(fold), .load_en(load_en), .load_idx(load_idx),
    .eval_go(eval_go), .syn_mode(syn_mode), .loads_done(loads_done)
  );

  rsc_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fold(fold), .byte_in(byte_in),
    .load(load_en), .load_idx(load_idx), .load_sym(load_sym), .stages(stages)
  );

  rsc_syneval u_eval (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(eval_go), .rem(stages),
    .busy(busy), .syn(syn)
  );

  assign shown    = syn_mode ? syn : stages;
  assign res_data = {{(16-SYM_W){1'b0}}, shown[2*res_sel+1],
                     {(16-SYM_W){1'b0}}, shown[2*res_sel]};

  assign run_o      = run;
  assign busy_o     = busy;
  assign syn_mode_o = syn_mode;
  assign clean_o    = syn_mode & loads_done & ~busy & (syn == '0);

  a_r8_busy_in_syn_mode: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> syn_mode);
  a_r11_clean_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clean_o) |-> $past(busy));
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_data[31:26] == '0 && res_data[15:10] == '0);
endmodule

// File: tb/rs_check_unit_test.sv
module rs_check_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_start = 0, byte_vld = 0, load_wr = 0, res_rd = 0;
  logic [7:0] byte_in = '0;
  logic [9:0] load_sym = '0;
  logic [1:0] res_sel = '0;
  logic [31:0] res_data;
  logic run_o, busy_o, syn_mode_o, clean_o;

  always #2 clk = ~clk;  // 250 MHz

  rs_check_unit uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
    .byte_vld(byte_vld), .byte_in(byte_in), .load_wr(load_wr), .load_sym(load_sym),
    .res_rd(res_rd), .res_sel(res_sel), .res_data(res_data), .run_o(run_o),
    .busy_o(busy_o), .syn_mode_o(syn_mode_o), .clean_o(clean_o)
  );

  int n_chk = 0, n_fail = 0;
  int gexp [0:1022];
  int glog [0:1023];
  int gpoly [0:8];
  logic [7:0] dat [0:519];
  int par [1:8];
  int got [1:8];
  int keep [1:8];
  int expv [1:8];
  int cw [0:540];
  logic pad_ok;

  task automatic chk(input logic ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic int tmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 1023];
  endfunction

  task automatic build_field();
    int v = 1;
    for (int e = 0; e < 1023; e++) begin
      gexp[e] = v;
      glog[v] = e;
      v = v << 1;
      if (v & 1024) v = v ^ 'h409;
    end
    for (int j = 0; j <= 8; j++) gpoly[j] = 0;
    gpoly[0] = 1;
    for (int r = 1; r <= 8; r++) begin
      int nw [0:8];
      for (int j = 0; j <= 8; j++)
        nw[j] = (j > 0 ? gpoly[j-1] : 0) ^ tmul(gpoly[j], gexp[r]);
      for (int j = 0; j <= 8; j++) gpoly[j] = nw[j];
    end
  endtask

  task automatic fill(input int seed);
    for (int j = 0; j < 520; j++) dat[j] = 8'((j * 37 + seed * 11 + 5) ^ (j >> 3));
  endtask

  // remainder by long division on a coefficient array
  task automatic model_parity(input int n);
    for (int i = 0; i < n + 8; i++) cw[i] = 0;
    for (int j = 0; j < n; j++) cw[n - 1 - j + 8] = dat[j];
    for (int d = n + 7; d >= 8; d--) begin
      int c = cw[d];
      if (c != 0) for (int k = 0; k <= 8; k++) cw[d - 8 + k] ^= tmul(c, gpoly[k]);
    end
    for (int k = 1; k <= 8; k++) par[k] = cw[k-1];
  endtask

  // direct evaluation of the received word at alpha^k
  task automatic model_syn(input int n, input int epos, input int emask);
    for (int k = 1; k <= 8; k++) begin
      int s = 0;
      for (int j = 0; j < n; j++) begin
        int b = dat[j] ^ ((j == epos) ? emask : 0);
        s ^= tmul(b, gexp[(k * (n - 1 - j + 8)) % 1023]);
      end
      for (int m = 1; m <= 8; m++) s ^= tmul(par[m], gexp[(k * (m - 1)) % 1023]);
      expv[k] = s;
    end
  endtask

  task automatic start_sector();
    @(negedge clk); ctl_wr = 1; ctl_start = 1;
    @(negedge clk); ctl_wr = 0; ctl_start = 0;
  endtask

  task automatic send(input int n, input int epos, input int emask);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); byte_vld = 1; byte_in = dat[j] ^ 8'((j == epos) ? emask : 0);
    end
    @(negedge clk); byte_vld = 0;
  endtask

  task automatic read_regs(input logic strobe);
    pad_ok = 1'b1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); res_sel = 2'(s); res_rd = strobe;
      #1;
      got[2*s+1] = int'(res_data[9:0]);
      got[2*s+2] = int'(res_data[25:16]);
      if (res_data[31:26] != 0 || res_data[15:10] != 0) pad_ok = 1'b0;
    end
    @(negedge clk); res_rd = 0;
  endtask

  task automatic load_one(input int v);
    @(negedge clk); load_wr = 1; load_sym = 10'(v);
    @(negedge clk); load_wr = 0;
  endtask

  task automatic cmp_par(input string tag);
    for (int k = 1; k <= 8; k++) chk(got[k] == par[k], tag, got[k], par[k]);
  endtask

  task automatic t_reset();
    read_regs(1'b0);
    chk(run_o == 0 && busy_o == 0 && syn_mode_o == 0 && clean_o == 0, "R1 flags", 0, 0);
    for (int k = 1; k <= 8; k++) chk(got[k] == 0, "R1 result zero", got[k], 0);
  endtask

  task automatic t_encode(input int n, input int seed);
    fill(seed);
    model_parity(n);
    start_sector();
    chk(run_o == 1, "R2 run set", run_o, 1);
    send(n, -1, 0);
    read_regs(1'b1);
    chk(run_o == 0, "R5 read clears run", run_o, 0);
    chk(pad_ok == 1, "R7 pad bits zero", pad_ok, 1);
    cmp_par("R3 R7 parity");
    send(5, -1, 0);  // run clear: must be ignored
    read_regs(1'b0);
    cmp_par("R4 ignored after freeze");
  endtask

  task automatic t_cap();
    fill(7);
    model_parity(518);
    start_sector();
    send(520, -1, 0);
    read_regs(1'b1);
    cmp_par("R6 cap at 518 bytes");
  endtask

  task automatic t_restart();
    start_sector();
    read_regs(1'b0);
    for (int k = 1; k <= 8; k++) chk(got[k] == 0, "R2 restart clears", got[k], 0);
    chk(syn_mode_o == 0, "R2 mode clear", syn_mode_o, 0);
    @(negedge clk); ctl_wr = 1; ctl_start = 0;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic t_decode(input int n, input int seed, input int epos, input int emask);
    int cnt;
    fill(seed);
    model_parity(n);
    model_syn(n, epos, emask);
    start_sector();
    send(n, epos, emask);
    load_one(par[8]);  // run still set: ignored
    chk(syn_mode_o == 0, "R8 load ignored while running", syn_mode_o, 0);
    read_regs(1'b1);
    for (int m = 8; m >= 1; m--) begin
      @(negedge clk); load_wr = 1; load_sym = 10'(par[m]);
      if (m == 7) chk(syn_mode_o == 1, "R8 first load sets mode", syn_mode_o, 1);
    end
    @(negedge clk); load_wr = 0;
    cnt = 0;
    while (busy_o && cnt < 40) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 8, "R9 busy length", cnt, 8);
    read_regs(1'b1);
    for (int k = 1; k <= 8; k++) chk(got[k] == expv[k], "R10 syndrome", got[k], expv[k]);
    chk(clean_o == (epos < 0), "R11 clean flag", clean_o, (epos < 0));
    for (int k = 1; k <= 8; k++) keep[k] = got[k];
    load_one(123);  // ninth load: ignored
    chk(busy_o == 0, "R8 ninth load no busy", busy_o, 0);
    read_regs(1'b0);
    for (int k = 1; k <= 8; k++) chk(got[k] == keep[k], "R8 ninth load ignored", got[k], keep[k]);
  endtask

  bit done = 0;
  initial begin
    build_field();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_encode(20, 1);
    t_encode(3, 4);
    t_cap();
    t_restart();
    t_decode(30, 2, -1, 0);
    t_decode(30, 3, 11, 8'h5a);
    t_decode(64, 5, 0, 8'h01);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule